// File: doc/BRIEF.md
# Hitless Reference Switch Phase Corrector

This block sits between a pair of qualified timing references and a phase-locked loop. It produces a virtual reference phase, which is the phase of the selected input plus a stored offset. When the selection moves to the other input, the block measures how far the two inputs are apart in phase. It adds that amount to the offset in the same clock edge as the switch, so the virtual reference has no phase step. Repeated switches build up a running offset.

All phases are unsigned counts of system-clock periods, taken modulo one 125 us frame. A low pulse on the active-low clear pin is accepted only if it is long enough. An accepted pulse starts a slow glide of the offset back to zero, along the shorter way round the phase circle. The glide rate is limited to 5 ns per frame. With a 20 ns system clock this means one count every four frame ticks. A busy flag is high while the glide runs.

Top module: `hitless_phase_corrector`

## Requirements
- R1: After reset the offset is 0, busy is 0, input 0 is selected, and the virtual phase equals the phase of input 0.
- R2: The virtual phase always equals (phase of the selected input + offset) mod FRAME_LEN, and the offset is always below FRAME_LEN.
- R3: A high switch strobe on a clock edge moves the selection to the other input. In the same edge it adds (old input phase − new input phase) mod FRAME_LEN to the offset, so the virtual phase is the same just before and just after the edge.
- R4: Without an accepted clear, the offset is the modulo sum of the errors measured at all switches since reset, and it does not change in cycles that have no switch.
- R5: The clear pin passes through a two-flop synchronizer. A low pulse is accepted on its rising edge only if it was low for at least LOW_CYCLES = ceil(MIN_LOW_PS / CLK_PERIOD_PS) clocks (15 at the defaults). A shorter pulse leaves the offset and busy unchanged.
- R6: An accepted clear sets busy whenever the offset is non-zero. Busy stays high until the offset is exactly 0, and busy is never high while the offset is 0.
- R7: While busy, the offset moves by exactly one count on each STEP_TICKS-th frame tick, counted from the clear edge. STEP_TICKS = ceil(CLK_PERIOD_PS / SLEW_PS), which is 4 at the defaults. A tick in the same cycle as the clear edge is not counted, and the offset is held between steps.
- R8: A glide step decrements an offset in 1..FRAME_LEN/2. It increments an offset above FRAME_LEN/2, and FRAME_LEN−1 wraps to 0.
- R9: A switch during a glide adds its error at once, and the glide carries on from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_phase | input | PH_W | Phase count of input reference 0 |
| ref1_phase | input | PH_W | Phase count of input reference 1 |
| switch_stb | input | 1 | One-cycle request to select the other reference |
| frame_tick | input | 1 | One pulse per 125 us frame |
| clear_n | input | 1 | Active-low asynchronous clear pin |
| vref_phase | output | PH_W | Virtual reference phase |
| offset | output | PH_W | Accumulated phase offset |
| busy | output | 1 | Glide toward zero in progress |

## Verification
Switches are tried with held input phases, to show the virtual phase has no step, and with phases changing every cycle, to show the error is taken from the current inputs. Clear pulses one clock shorter than the limit and exactly at the limit separate rejection from acceptance. Glides are started from small offsets, from offsets just below the frame length, and from offsets that a mid-glide switch alters. These show the decrement direction, the increment direction with wrap, and continuation after a switch. A long random mix of switches, frame ticks and clear pulses of lengths near the limit checks how these events interact.

// File: rtl/phc_pkg.sv
`timescale 1ns/1ps
package phc_pkg;

  // Ceiling division used to derive cycle counts from picosecond figures.
  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Sum of two phases on a circle of length frame.
  function automatic int unsigned ph_add(int unsigned a, int unsigned b, int unsigned frame);
    int unsigned s;
    s = a + b;
    return (s >= frame) ? s - frame : s;
  endfunction

  // Difference a - b on a circle of length frame.
  function automatic int unsigned ph_sub(int unsigned a, int unsigned b, int unsigned frame);
    return (a >= b) ? a - b : a + frame - b;
  endfunction

  // One count toward zero along the shorter arc.
  function automatic int unsigned ph_toward_zero(int unsigned x, int unsigned frame);
    if (x == 0) return 0;
    if (x <= frame / 2) return x - 1;
    return (x == frame - 1) ? 0 : x + 1;
  endfunction

endpackage

// File: rtl/phc_clear_qual.sv
`timescale 1ns/1ps
module phc_clear_qual #(
  parameter int unsigned LOW_CYCLES = 15,
  localparam int CW = $clog2(LOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_n,
  output logic clr_evt
);
  logic          sync1, sync2, sync_prev;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b1;
      sync2     <= 1'b1;
      sync_prev <= 1'b1;
      low_cnt   <= '0;
    end else begin
      sync1     <= clear_n;
      sync2     <= sync1;
      sync_prev <= sync2;
      if (sync2)
        low_cnt <= '0;
      else if (low_cnt != CW'(LOW_CYCLES))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  // Accept on the rising edge that ends a long enough low pulse.
  assign clr_evt = sync2 & ~sync_prev & (low_cnt == CW'(LOW_CYCLES));
endmodule

// File: rtl/phc_slew_timer.sv
`timescale 1ns/1ps
module phc_slew_timer #(
  parameter int unsigned STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic frame_tick,
  input  logic clr_evt,
  output logic step_evt
);
  generate
    if (STEP_TICKS <= 1) begin : g_every_tick
      assign step_evt = busy & frame_tick & ~clr_evt;
    end else begin : g_divided
      localparam int TW = $clog2(STEP_TICKS + 1);
      logic [TW-1:0] tick_cnt;

      assign step_evt = busy & frame_tick & ~clr_evt & (tick_cnt == TW'(STEP_TICKS - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          tick_cnt <= '0;
        else if (clr_evt || step_evt || !busy)
          tick_cnt <= '0;
        else if (frame_tick)
          tick_cnt <= tick_cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/phc_ref_select.sv
`timescale 1ns/1ps
module phc_ref_select
  import phc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 6250,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ref0_phase,
  input  logic [PH_W-1:0] ref1_phase,
  input  logic            sw_evt,
  input  logic [PH_W-1:0] offset,
  output logic [PH_W-1:0] err,
  output logic [PH_W-1:0] vref_phase
);
  logic            sel;
  logic [PH_W-1:0] old_ph, new_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel <= 1'b0;
    else if (sw_evt)
      sel <= ~sel;
  end

  assign old_ph     = sel ? ref1_phase : ref0_phase;
  assign new_ph     = sel ? ref0_phase : ref1_phase;
  assign err        = PH_W'(ph_sub(32'(old_ph), 32'(new_ph), FRAME_LEN));
  assign vref_phase = PH_W'(ph_add(32'(old_ph), 32'(offset), FRAME_LEN));
endmodule

// File: rtl/phc_offset_acc.sv
`timescale 1ns/1ps
module phc_offset_acc
  import phc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 6250,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] err,
  input  logic            sw_evt,
  input  logic            step_evt,
  input  logic            clr_evt,
  output logic [PH_W-1:0] offset,
  output logic            busy
);
  logic [PH_W-1:0] off_sw, off_nx;

  assign off_sw = sw_evt ? PH_W'(ph_add(32'(offset), 32'(err), FRAME_LEN)) : offset;
  assign off_nx = step_evt ? PH_W'(ph_toward_zero(32'(off_sw), FRAME_LEN)) : off_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      busy   <= 1'b0;
    end else begin
      offset <= off_nx;
      busy   <= (busy | clr_evt) & (off_nx != '0);
    end
  end
endmodule

// File: rtl/hitless_phase_corrector.sv
`timescale 1ns/1ps
module hitless_phase_corrector
  import phc_pkg::*;
#(
  parameter int unsigned FRAME_LEN     = 6250,
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned MIN_LOW_PS    = 300000,
  parameter int unsigned SLEW_PS       = 5000,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ref0_phase,
  input  logic [PH_W-1:0] ref1_phase,
  input  logic            switch_stb,
  input  logic            frame_tick,
  input  logic            clear_n,
  output logic [PH_W-1:0] vref_phase,
  output logic [PH_W-1:0] offset,
  output logic            busy
);
  localparam int unsigned LOW_CYCLES = ceil_div(MIN_LOW_PS, CLK_PERIOD_PS);
  localparam int unsigned STEP_TICKS = ceil_div(CLK_PERIOD_PS, SLEW_PS);

  logic            sw_evt;
  logic            clr_evt;
  logic            step_evt;
  logic [PH_W-1:0] err;

  assign sw_evt = switch_stb;

  phc_clear_qual #(.LOW_CYCLES(LOW_CYCLES)) clear_qual_i (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .clr_evt(clr_evt)
  );

  phc_slew_timer #(.STEP_TICKS(STEP_TICKS)) slew_timer_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .frame_tick(frame_tick),
    .clr_evt(clr_evt), .step_evt(step_evt)
  );

  phc_ref_select #(.FRAME_LEN(FRAME_LEN)) ref_select_i (
    .clk(clk), .rst_n(rst_n), .ref0_phase(ref0_phase), .ref1_phase(ref1_phase),
    .sw_evt(sw_evt), .offset(offset), .err(err), .vref_phase(vref_phase)
  );

  phc_offset_acc #(.FRAME_LEN(FRAME_LEN)) offset_acc_i (
    .clk(clk), .rst_n(rst_n), .err(err), .sw_evt(sw_evt), .step_evt(step_evt),
    .clr_evt(clr_evt), .offset(offset), .busy(busy)
  );
endmodule

// File: rtl/hitless_phase_corrector_chk.sv
`timescale 1ns/1ps
module hitless_phase_corrector_chk
  import phc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 6250,
  localparam int PH_W = $clog2(FRAME_LEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_evt,
  input logic            step_evt,
  input logic            clr_evt,
  input logic [PH_W-1:0] err,
  input logic [PH_W-1:0] offset,
  input logic            busy
);
  localparam logic [PH_W-1:0] HALF = PH_W'(FRAME_LEN / 2);

  AST_OFFSET_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    offset < PH_W'(FRAME_LEN)); // R2

  AST_SWITCH_ADDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_evt && !step_evt) |=> offset == PH_W'(ph_add(32'($past(offset)), 32'($past(err)), FRAME_LEN))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_evt && !busy) |=> $stable(offset)); // R4

  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> offset != '0); // R6

  AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (busy || offset == '0)); // R6

  AST_SLEW_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_evt |=> (offset == $past(offset)) ||
                (offset == PH_W'(ph_toward_zero(32'($past(offset)), FRAME_LEN)))); // R7

  AST_LOWER_HALF_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !sw_evt && offset <= HALF) |=> offset == $past(offset) - 1'b1); // R8

  AST_UPPER_HALF_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !sw_evt && offset > HALF && offset != PH_W'(FRAME_LEN - 1)) |=> offset == $past(offset) + 1'b1); // R8
endmodule

bind hitless_phase_corrector hitless_phase_corrector_chk #(.FRAME_LEN(FRAME_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_evt(sw_evt), .step_evt(step_evt), .clr_evt(clr_evt),
  .err(err), .offset(offset), .busy(busy)
);

// File: tb/hitless_phase_corrector_tb_top.sv
`timescale 1ns/1ps
module hitless_phase_corrector_tb_top;
  localparam int unsigned F     = 6250;
  localparam int          PH_W  = $clog2(F);
  localparam int unsigned LOWC  = 15;   // 300 ns / 20 ns
  localparam int unsigned STEPT = 4;    // 20 ns / 5 ns

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PH_W-1:0] ref0_phase = '0, ref1_phase = '0;
  logic            switch_stb = 1'b0, frame_tick = 1'b0, clear_n = 1'b1;
  logic [PH_W-1:0] vref_phase, offset;
  logic            busy;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  hitless_phase_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .ref0_phase(ref0_phase), .ref1_phase(ref1_phase),
    .switch_stb(switch_stb), .frame_tick(frame_tick), .clear_n(clear_n),
    .vref_phase(vref_phase), .offset(offset), .busy(busy)
  );

  // Bench arithmetic, written independently with modulo operators.
  function automatic int unsigned b_mod(int x);
    return int'((x % int'(F) + int'(F)) % int'(F));
  endfunction
  function automatic int unsigned b_glide(int unsigned x);
    int s;
    s = (x > F / 2) ? int'(x) - int'(F) : int'(x);
    if (s > 0) s = s - 1;
    else if (s < 0) s = s + 1;
    return b_mod(s);
  endfunction

  // Reference model state.
  int unsigned m_off, m_tick, m_low;
  bit          m_sel, m_busy, m_s1, m_s2, m_sp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_off = 0; m_tick = 0; m_low = 0; m_sel = 0; m_busy = 0;
      m_s1 = 1; m_s2 = 1; m_sp = 1;
    end else begin
      bit qual, stp;
      int unsigned o1, nx, oldp, newp;
      qual = m_s2 && !m_sp && (m_low >= LOWC);
      oldp = m_sel ? ref1_phase : ref0_phase;
      newp = m_sel ? ref0_phase : ref1_phase;
      o1   = switch_stb ? b_mod(int'(m_off) + int'(oldp) - int'(newp)) : m_off;
      stp  = m_busy && frame_tick && (m_tick == STEPT - 1) && !qual;
      nx   = stp ? b_glide(o1) : o1;
      if (qual || stp || !m_busy) m_tick = 0;
      else if (frame_tick) m_tick = m_tick + 1;
      m_busy = (qual || m_busy) && (nx != 0);
      m_off  = nx;
      if (switch_stb) m_sel = !m_sel;
      m_low = m_s2 ? 0 : ((m_low < LOWC) ? m_low + 1 : m_low);
      m_sp = m_s2; m_s2 = m_s1; m_s1 = clear_n;
    end
  end

  task automatic check(string tag, int unsigned act, int unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check("R2 vref", vref_phase, b_mod(int'(m_sel ? ref1_phase : ref0_phase) + int'(m_off)));
    check("R7 offset vs model", offset, m_off);
    check("R6 busy vs model", busy, m_busy);
  endtask

  task automatic add_err(int unsigned d);
    if (!m_sel) begin ref0_phase = PH_W'(d); ref1_phase = '0; end
    else begin ref1_phase = PH_W'(d); ref0_phase = '0; end
    switch_stb = 1'b1; cyc(); switch_stb = 1'b0;
  endtask

  task automatic clear_pulse(int n);
    clear_n = 1'b0;
    repeat (n) cyc();
    clear_n = 1'b1;
    repeat (5) cyc();
  endtask

  task automatic run_ticks(int n);
    frame_tick = 1'b1;
    repeat (n) cyc();
    frame_tick = 1'b0;
  endtask

  task automatic drain();
    frame_tick = 1'b1;
    for (int i = 0; i < 20000 && busy; i++) cyc();
    frame_tick = 1'b0;
    cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int unsigned v_before, o0;
    int clr_left;
    void'($urandom(32'd20240611));
    ref0_phase = PH_W'(123); ref1_phase = PH_W'(77);
    repeat (3) @(negedge clk);
    check("R1 reset offset", offset, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset vref", vref_phase, 123);
    rst_n = 1'b1;
    cyc();
    check("R1 vref on input 0", vref_phase, 123);

    // R3: no step at a switch with held inputs
    ref0_phase = PH_W'(1000); ref1_phase = PH_W'(200);
    cyc();
    v_before = vref_phase;
    switch_stb = 1'b1; cyc(); switch_stb = 1'b0;
    check("R3 vref unchanged at switch", vref_phase, v_before);
    check("R3 offset after first switch", offset, 800);
    // R4: second switch accumulates
    ref0_phase = PH_W'(50);
    cyc();
    v_before = vref_phase;
    switch_stb = 1'b1; cyc(); switch_stb = 1'b0;
    check("R3 vref unchanged at second switch", vref_phase, v_before);
    check("R4 accumulated offset", offset, 950);
    repeat (5) cyc();
    check("R4 offset held without switch", offset, 950);

    // R5: short pulse ignored, limit pulse accepted
    clear_pulse(LOWC - 1);
    check("R5 short clear offset", offset, 950);
    check("R5 short clear busy", busy, 0);
    clear_n = 1'b0;
    repeat (LOWC) cyc();
    clear_n = 1'b1;
    for (int i = 0; i < 10 && !busy; i++) cyc();
    check("R5 clear at limit accepted", busy, 1);
    check("R7 no jump at clear", offset, 950);
    o0 = offset;
    run_ticks(STEPT - 1);
    check("R7 held before step", offset, o0);
    run_ticks(1);
    check("R8 decrement in lower half", offset, o0 - 1);
    run_ticks(36);
    check("R7 one count per step", offset, o0 - 10);
    drain();
    check("R6 glide ends at zero", offset, 0);
    check("R6 busy drops at zero", busy, 0);

    // R8: upper half increments and wraps
    add_err(F - 3);
    check("R4 offset set near frame end", offset, F - 3);
    clear_pulse(LOWC + 2);
    run_ticks(STEPT);
    check("R8 increment in upper half", offset, F - 2);
    run_ticks(2 * STEPT);
    check("R8 wrap to zero", offset, 0);
    check("R6 busy low after wrap", busy, 0);

    // R9: switch during glide
    add_err(20);
    clear_pulse(LOWC);
    run_ticks(2 * STEPT);
    check("R9 glide before switch", offset, 18);
    add_err(5);
    check("R9 error added during glide", offset, 23);
    check("R9 busy kept", busy, 1);
    run_ticks(STEPT);
    check("R9 glide continues", offset, 22);
    drain();
    check("R9 glide finishes", offset, 0);

    // Random mix
    clr_left = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 4 == 0) ref0_phase = PH_W'($urandom % F);
      if ($urandom % 4 == 0) ref1_phase = PH_W'($urandom % F);
      switch_stb = ($urandom % 25 == 0);
      frame_tick = ($urandom % 2 == 0);
      if (clr_left > 0) begin clear_n = 1'b0; clr_left--; end
      else begin
        clear_n = 1'b1;
        if ($urandom % 200 == 0) clr_left = 12 + int'($urandom % 7);
      end
      cyc();
    end
    switch_stb = 1'b0; clear_n = 1'b1;
    repeat (5) cyc();
    summary();
  end
endmodule